// File: doc/BRIEF.md
# Hysteretic PLL Digital Lock Detector

This block decides whether a phase-locked loop is in lock by timing the error pulse that the phase detector emits on every comparison cycle. A fast sampling clock counts how many of its cycles the error pulse is high, and a strobe marks the end of each comparison cycle. At that strobe the measured width is judged against two thresholds. A tight acquire threshold decides whether the cycle counts towards gaining lock. A looser release threshold decides whether a locked loop has slipped.

While unlocked, the block counts consecutive cycles whose error is below the acquire threshold. A select input chooses whether three or five such cycles are needed. Once the flag is set, it drops only when a single cycle shows an error wider than the release threshold. Errors that fall between the two thresholds leave the flag set, and this gap gives the detector its hysteresis. Both thresholds are parameters given in sampling-clock cycles. The defaults, 15 and 25, match 15 ns and 25 ns at a 1 GHz sampling clock.

Top module: `lock_detect`

## Requirements
- R1: A synchronous active-low reset clears the lock flag to 0 and discards any partial run of good cycles. After reset, a complete new run is needed to gain lock.
- R2: The measured width of a comparison cycle is the number of sampling-clock edges at which the error pulse was high. The count runs from the edge after the previous strobe up to and including the strobe edge. Separate bursts within one cycle add together.
- R3: With the select input at 0, the lock flag rises at the strobe edge of the third consecutive cycle whose width is below the acquire threshold.
- R4: With the select input at 1, the lock flag rises at the strobe edge of the fifth consecutive such cycle.
- R5: While unlocked, a cycle whose width is equal to or above the acquire threshold clears the run of good cycles to zero.
- R6: While locked, a cycle whose width is at most the release threshold leaves the lock flag high. This includes widths from the acquire threshold up to and including the release threshold.
- R7: While locked, a single cycle whose width exceeds the release threshold clears the lock flag at that strobe edge.
- R8: A change of the select input while unlocked applies at the very next strobe. The run already counted is compared with the newly selected length.
- R9: The lock flag changes only at a clock edge where the strobe is high.
- R10: The width count saturates at its maximum and does not wrap. A very long error pulse is therefore always judged above the release threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cycleEnd | input | 1 | One-clock strobe on the last sampling cycle of each comparison cycle |
| errPulse | input | 1 | Phase-detector error pulse, high while error is present |
| selFive | input | 1 | 0: three good cycles to lock, 1: five good cycles to lock |
| lockFlag | output | 1 | Active-high lock indication |

## Verification
Streaks of narrow pulses are run with each select setting, and the flag must rise exactly on the third or the fifth strobe. This separates the two run lengths and catches an off-by-one in the count. Widths exactly at the acquire threshold and one below it separate strict from non-strict acquire comparisons. Widths of 20, 25 and 26 while locked show whether the release threshold is used and whether it is inclusive. A width split into two bursts, a pulse far past the count range, a reset in the middle of a run and a select change in the middle of a run check how widths add up, saturation, clearing of the run, and when the select input takes effect.

// File: rtl/lock_pkg.sv
package lock_pkg;

  // control -> datapath
  typedef struct packed {
    logic measClear;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic evalValid;
    logic good;
    logic bad;
  } verdict_t;

endpackage

// File: rtl/lock_meas.sv
module lock_meas
  import lock_pkg::*;
#(
  parameter int ACQ_CYCLES = 15,
  parameter int REL_CYCLES = 25,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             errPulse,
  input  logic             cycleEnd,
  input  ctlStrobe_t       ctl,
  output verdict_t         verdict,
  output logic [CNT_W-1:0] measWidth
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ACQ_L   = CNT_W'(ACQ_CYCLES);
  localparam logic [CNT_W-1:0] REL_L   = CNT_W'(REL_CYCLES);

  logic [CNT_W-1:0] widthCnt;
  logic             atMax;

  assign atMax = (widthCnt == CNT_MAX);

  // width including the current sampling edge, saturated
  always_comb begin
    if (errPulse && !atMax) measWidth = widthCnt + 1'b1;
    else                    measWidth = widthCnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widthCnt <= '0;
    end else if (ctl.measClear) begin
      widthCnt <= '0;
    end else if (errPulse && !atMax) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  always_comb begin
    verdict.evalValid = cycleEnd;
    verdict.good      = (measWidth < ACQ_L);
    verdict.bad       = (measWidth > REL_L);
  end

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
#(
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 5,
  parameter int GOOD_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selFive,
  input  verdict_t          verdict,
  output ctlStrobe_t        ctl,
  output logic              lockFlag,
  output logic [GOOD_W-1:0] goodCnt
);

  localparam logic [GOOD_W-1:0] SHORT_L = GOOD_W'(RUN_SHORT);
  localparam logic [GOOD_W-1:0] LONG_L  = GOOD_W'(RUN_LONG);

  logic [GOOD_W-1:0] runNeed;
  logic [GOOD_W-1:0] goodNext;

  assign runNeed  = selFive ? LONG_L : SHORT_L;
  assign goodNext = goodCnt + 1'b1;

  always_comb begin
    ctl.measClear = verdict.evalValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lockFlag <= 1'b0;
      goodCnt  <= '0;
    end else if (verdict.evalValid) begin
      if (lockFlag) begin
        if (verdict.bad) begin
          lockFlag <= 1'b0;
          goodCnt  <= '0;
        end
      end else if (verdict.good) begin
        if (goodNext >= runNeed) begin
          lockFlag <= 1'b1;
          goodCnt  <= '0;
        end else begin
          goodCnt  <= goodNext;
        end
      end else begin
        goodCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/lock_detect.sv
module lock_detect
  import lock_pkg::*;
#(
  parameter int ACQ_CYCLES = 15,
  parameter int REL_CYCLES = 25,
  parameter int RUN_SHORT  = 3,
  parameter int RUN_LONG   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycleEnd,
  input  logic errPulse,
  input  logic selFive,
  output logic lockFlag
);

  localparam int CNT_W  = $clog2(REL_CYCLES + 2);
  localparam int GOOD_W = $clog2(RUN_LONG + 1);

  ctlStrobe_t        ctl;
  verdict_t          verdict;
  logic [CNT_W-1:0]  measWidth;
  logic [GOOD_W-1:0] goodCnt;

  lock_meas #(
    .ACQ_CYCLES(ACQ_CYCLES),
    .REL_CYCLES(REL_CYCLES),
    .CNT_W     (CNT_W)
  ) u_meas (
    .clk      (clk),
    .rst_n    (rst_n),
    .errPulse (errPulse),
    .cycleEnd (cycleEnd),
    .ctl      (ctl),
    .verdict  (verdict),
    .measWidth(measWidth)
  );

  lock_ctrl #(
    .RUN_SHORT(RUN_SHORT),
    .RUN_LONG (RUN_LONG),
    .GOOD_W   (GOOD_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .selFive (selFive),
    .verdict (verdict),
    .ctl     (ctl),
    .lockFlag(lockFlag),
    .goodCnt (goodCnt)
  );

endmodule

// File: rtl/lock_detect_chk.sv
module lock_detect_chk #(
  parameter int ACQ_CYCLES = 15,
  parameter int REL_CYCLES = 25,
  parameter int RUN_SHORT  = 3,
  parameter int CNT_W      = 5,
  parameter int GOOD_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cycleEnd,
  input logic              errPulse,
  input logic              selFive,
  input logic              lockFlag,
  input logic [CNT_W-1:0]  measWidth,
  input logic [CNT_W-1:0]  widthCnt,
  input logic [GOOD_W-1:0] goodCnt
);

  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  ACQ_L   = CNT_W'(ACQ_CYCLES);
  localparam logic [CNT_W-1:0]  REL_L   = CNT_W'(REL_CYCLES);
  localparam logic [GOOD_W-1:0] PRE_SHORT = GOOD_W'(RUN_SHORT - 1);

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !cycleEnd |=> $stable(lockFlag)); // R9

  AST_RELEASE_ON_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (lockFlag && cycleEnd && measWidth > REL_L) |=> !lockFlag); // R7

  AST_KEEP_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (lockFlag && cycleEnd && measWidth <= REL_L) |=> lockFlag); // R6

  AST_NO_ACQ_ON_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockFlag && cycleEnd && measWidth >= ACQ_L) |=> (!lockFlag && goodCnt == '0)); // R5

  AST_ACQ_SHORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockFlag && cycleEnd && !selFive && measWidth < ACQ_L && goodCnt == PRE_SHORT)
    |=> lockFlag); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycleEnd && errPulse && widthCnt == CNT_MAX) |=> widthCnt == CNT_MAX); // R10

endmodule

bind lock_detect lock_detect_chk #(
  .ACQ_CYCLES(ACQ_CYCLES),
  .REL_CYCLES(REL_CYCLES),
  .RUN_SHORT (RUN_SHORT),
  .CNT_W     (CNT_W),
  .GOOD_W    (GOOD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cycleEnd (cycleEnd),
  .errPulse (errPulse),
  .selFive  (selFive),
  .lockFlag (lockFlag),
  .measWidth(measWidth),
  .widthCnt (u_meas.widthCnt),
  .goodCnt  (goodCnt)
);

// File: tb/tb_lock_detect.sv
module tb_lock_detect;

  logic clk = 1'b0;
  logic rst_n;
  logic cycleEnd;
  logic errPulse;
  logic selFive;
  logic lockFlag;

  int errors = 0;
  int checks = 0;

  localparam int PERIOD = 80;
  localparam int NVEC   = 24;

  lock_detect dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cycleEnd(cycleEnd),
    .errPulse(errPulse),
    .selFive (selFive),
    .lockFlag(lockFlag)
  );

  always #4 clk = ~clk;

  // {req[3:0], sel, width[6:0], expLock}
  localparam logic [12:0] VEC [NVEC] = '{
    {4'd3,  1'b0, 7'd5,  1'b0},
    {4'd3,  1'b0, 7'd5,  1'b0},
    {4'd3,  1'b0, 7'd5,  1'b1},   // R3 third good cycle
    {4'd6,  1'b0, 7'd20, 1'b1},   // R6 in band
    {4'd6,  1'b0, 7'd25, 1'b1},   // R6 at release limit
    {4'd7,  1'b0, 7'd26, 1'b0},   // R7 above release
    {4'd5,  1'b0, 7'd14, 1'b0},
    {4'd5,  1'b0, 7'd15, 1'b0},   // R5 at acquire threshold breaks run
    {4'd5,  1'b0, 7'd0,  1'b0},
    {4'd5,  1'b0, 7'd0,  1'b0},   // R5 would lock if run survived
    {4'd3,  1'b0, 7'd0,  1'b1},
    {4'd10, 1'b0, 7'd70, 1'b0},   // R10 saturated width releases
    {4'd4,  1'b1, 7'd14, 1'b0},
    {4'd4,  1'b1, 7'd14, 1'b0},
    {4'd4,  1'b1, 7'd14, 1'b0},
    {4'd4,  1'b1, 7'd14, 1'b0},
    {4'd4,  1'b1, 7'd14, 1'b1},   // R4 fifth good cycle
    {4'd7,  1'b1, 7'd30, 1'b0},
    {4'd8,  1'b1, 7'd3,  1'b0},
    {4'd8,  1'b1, 7'd3,  1'b0},
    {4'd8,  1'b0, 7'd3,  1'b1},   // R8 select drop applies at once
    {4'd10, 1'b0, 7'd79, 1'b0},
    {4'd8,  1'b1, 7'd3,  1'b0},
    {4'd8,  1'b1, 7'd3,  1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lockFlag=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one comparison cycle; pulse split into two bursts when gap>0
  task automatic runCycle(input int w1, input int gap, input int w2);
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      errPulse = (i < w1) || (i >= w1 + gap && i < w1 + gap + w2);
      cycleEnd = (i == PERIOD - 1);
    end
    @(negedge clk);
    errPulse = 1'b0;
    cycleEnd = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; cycleEnd = 1'b0; errPulse = 1'b0; selFive = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", lockFlag, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      selFive = VEC[v][8];
      runCycle(int'(VEC[v][7:1]), 0, 0);
      check($sformatf("R%0d", VEC[v][12:9]), lockFlag, VEC[v][0]);
    end

    // R2: two bursts of 8 add to 16, never good
    doReset();
    selFive = 1'b0;
    for (int k = 0; k < 3; k++) runCycle(8, 10, 8);
    check("R2", lockFlag, 1'b0);
    // R2: two bursts of 7 add to 14, good
    for (int k = 0; k < 3; k++) runCycle(7, 10, 7);
    check("R2", lockFlag, 1'b1);

    // R9: wide pulse mid-cycle does not drop lock before strobe
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      errPulse = 1'b1;
    end
    @(negedge clk);
    check("R9", lockFlag, 1'b1);
    errPulse = 1'b0;
    for (int i = 0; i < 30; i++) @(negedge clk);
    cycleEnd = 1'b1;
    @(negedge clk);
    cycleEnd = 1'b0;
    check("R7", lockFlag, 1'b0);

    // R1: reset clears partial run
    runCycle(2, 0, 0);
    runCycle(2, 0, 0);
    doReset();
    check("R1", lockFlag, 1'b0);
    runCycle(2, 0, 0);
    runCycle(2, 0, 0);
    check("R1", lockFlag, 1'b0);
    runCycle(2, 0, 0);
    check("R1", lockFlag, 1'b1);

    // R1: reset drops an established lock
    doReset();
    check("R1", lockFlag, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule